// File: doc/BRIEF.md
# Compressed-Mode Sequencer

This block follows the encoding mode of an instruction stream that mixes 10-bit, 16-bit, paired 16+16-bit and 32-bit instructions. For each instruction that the decoder accepts, it receives the instruction's length class and its mode-switch field. From these it registers the mode in which the next instruction has to be decoded. Field decoding and the realignment datapath are handled elsewhere.

The state machine has three named states. `MODE_UNC` (code 2'b00) is uncompressed. `MODE_CMP` (code 2'b01) is compressed. `MODE_ONE` (code 2'b10) is a slot that holds exactly one 32-bit instruction and then returns to compressed mode without any switching instruction.

The named transitions are:
- **T_ENTER_CMP**: a 10-bit instruction with switch bit 0 set moves `MODE_UNC` to `MODE_CMP`.
- **T_HOLD_UNC**: any other legal uncompressed instruction keeps `MODE_UNC`.
- **T_HOLD_CMP**: a 16-bit instruction with switch 2'b00, or any 16+16-bit instruction, keeps `MODE_CMP`.
- **T_SLOT**: a 16-bit instruction with switch 2'b01 moves `MODE_CMP` to `MODE_ONE`.
- **T_LEAVE_CMP**: a 16-bit instruction with switch 2'b10 moves `MODE_CMP` to `MODE_UNC`.
- **T_SLOT_DONE**: a 32-bit instruction moves `MODE_ONE` to `MODE_CMP`.
- **T_BRANCH**: a legal taken branch moves any state to `MODE_UNC`.
- **T_RESTORE**: loads a saved mode.

Each illegal class/mode pairing is flagged. For interrupts, the saved context is simply the value on `mode_o`, and `restore_valid` puts it back.

Top module: `cmode_seq`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (uncompressed) and `illegal_o` is low.
- R2: Class codes are 2'b00 for 10-bit, 2'b01 for 16-bit, 2'b10 for 16+16-bit and 2'b11 for 32-bit. In uncompressed mode, a 32-bit instruction keeps the mode uncompressed.
- R3: In uncompressed mode, a 10-bit instruction moves to compressed (2'b01) when `ins_switch[0]` is 1, and stays uncompressed when it is 0.
- R4: In compressed mode, a 16-bit instruction with switch 2'b00 stays compressed, with 2'b01 moves to the one-shot slot (2'b10), and with 2'b10 moves to uncompressed.
- R5: In compressed mode, a 16+16-bit instruction leaves the mode compressed, whatever its switch field holds.
- R6: In the one-shot slot, a 32-bit instruction returns the mode to compressed.
- R7: A 16-bit or 16+16-bit instruction in uncompressed mode is illegal. So is a 10-bit or 32-bit instruction in compressed mode, any class other than 32-bit in the one-shot slot, and a 16-bit switch value of 2'b11.
- R8: An illegal instruction raises `illegal_o` for exactly the one cycle after its handshake and leaves `mode_o` unchanged, even when `branch_taken` is set.
- R9: The mode changes only on a cycle where `ins_valid` and `ins_ready` are both high, or where `restore_valid` is high.
- R10: A legal instruction with `branch_taken` high sets the mode to uncompressed, whatever its switch field and whatever the current mode.
- R11: `restore_valid` loads `restore_mode` into the mode on the next edge and takes priority over a same-cycle handshake. A restored code of 2'b11 yields uncompressed. A restored one-shot slot still returns to compressed after one 32-bit instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Decoded instruction present |
| ins_ready | input | 1 | Decoder accepts the instruction |
| ins_class | input | 2 | Length class of the instruction |
| ins_switch | input | 2 | Mode-switch request field |
| branch_taken | input | 1 | Instruction is a taken branch; its target is uncompressed |
| restore_valid | input | 1 | Load a saved mode |
| restore_mode | input | 2 | Saved mode to load |
| mode_o | output | 2 | Mode for the next instruction; also the value saved on interrupt |
| illegal_o | output | 1 | One-cycle pulse for an illegal class/mode pairing |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a taken branch and the return from the one-shot slot. The bench provokes it by accepting a 32-bit instruction in the slot with `branch_taken` set, and checks that the branch wins (the mode becomes uncompressed rather than compressed).

The second pair is a restore and an instruction handshake. The bench provokes it by asserting `restore_valid` while a legal instruction that would change the mode is accepted, and checks that only the restored value appears and that no illegal pulse is raised.

// File: rtl/cmode_pkg.sv
package cmode_pkg;
    localparam int MODE_W  = 2;
    localparam int CLASS_W = 2;
    localparam int SW_W    = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_UNC = 2'b00,
        MODE_CMP = 2'b01,
        MODE_ONE = 2'b10
    } mode_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_I10  = 2'b00,
        CLS_I16  = 2'b01,
        CLS_I16P = 2'b10,
        CLS_I32  = 2'b11
    } class_e;

    localparam logic [SW_W-1:0] SW_STAY = 2'b00;
    localparam logic [SW_W-1:0] SW_ONCE = 2'b01;
    localparam logic [SW_W-1:0] SW_GOUN = 2'b10;
endpackage

// File: rtl/cmode_gate.sv
module cmode_gate
    import cmode_pkg::*;
(
    input  mode_e                cur_mode,
    input  class_e               cls,
    input  logic [SW_W-1:0]      sw,
    output logic                 legal
);
    always_comb begin
        legal = 1'b0;
        unique case (cur_mode)
            MODE_UNC: legal = (cls == CLS_I10) || (cls == CLS_I32);
            MODE_CMP: legal = (cls == CLS_I16P) ||
                              ((cls == CLS_I16) && (sw != 2'b11));
            MODE_ONE: legal = (cls == CLS_I32);
            default:  legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmode_step.sv
module cmode_step
    import cmode_pkg::*;
(
    input  mode_e                cur_mode,
    input  class_e               cls,
    input  logic [SW_W-1:0]      sw,
    input  logic                 branch,
    output mode_e                step_mode
);
    always_comb begin
        step_mode = cur_mode;
        unique case (cur_mode)
            MODE_UNC: begin
                if (cls == CLS_I10 && sw[0]) step_mode = MODE_CMP; // T_ENTER_CMP
                else                         step_mode = MODE_UNC; // T_HOLD_UNC
            end
            MODE_CMP: begin
                if (cls == CLS_I16) begin
                    if (sw == SW_ONCE)      step_mode = MODE_ONE;  // T_SLOT
                    else if (sw == SW_GOUN) step_mode = MODE_UNC;  // T_LEAVE_CMP
                    else                    step_mode = MODE_CMP;  // T_HOLD_CMP
                end else begin
                    step_mode = MODE_CMP;
                end
            end
            MODE_ONE: step_mode = MODE_CMP;                        // T_SLOT_DONE
            default:  step_mode = MODE_UNC;
        endcase
        if (branch) step_mode = MODE_UNC;                          // T_BRANCH
    end
endmodule

// File: rtl/cmode_seq.sv
module cmode_seq
    import cmode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic               ins_ready,
    input  logic [CLASS_W-1:0] ins_class,
    input  logic [SW_W-1:0]    ins_switch,
    input  logic               branch_taken,
    input  logic               restore_valid,
    input  logic [MODE_W-1:0]  restore_mode,
    output logic [MODE_W-1:0]  mode_o,
    output logic               illegal_o
);
    mode_e  mode_q, mode_d, step_mode, rest_mode;
    class_e cls;
    logic   fire, legal, illegal_d, illegal_q;

    assign cls  = class_e'(ins_class);
    assign fire = ins_valid && ins_ready;

    cmode_gate u_gate (
        .cur_mode (mode_q),
        .cls      (cls),
        .sw       (ins_switch),
        .legal    (legal)
    );

    cmode_step u_step (
        .cur_mode  (mode_q),
        .cls       (cls),
        .sw        (ins_switch),
        .branch    (branch_taken),
        .step_mode (step_mode)
    );

    always_comb begin
        unique case (restore_mode)
            2'b01:   rest_mode = MODE_CMP;
            2'b10:   rest_mode = MODE_ONE;
            default: rest_mode = MODE_UNC;
        endcase
    end

    always_comb begin
        mode_d    = mode_q;
        illegal_d = 1'b0;
        if (restore_valid) begin
            mode_d = rest_mode;                                    // T_RESTORE
        end else if (fire) begin
            if (legal) mode_d    = step_mode;
            else       illegal_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_UNC;
            illegal_q <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            illegal_q <= illegal_d;
        end
    end

    always_comb begin
        mode_o    = mode_q;
        illegal_o = illegal_q;
    end

    assert_mode_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);

    assert_slot_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && fire && ins_class == 2'b11 && !branch_taken && !restore_valid)
        |=> (mode_o == 2'b01));

    assert_illegal_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !$past(restore_valid)) |-> $stable(mode_o));

    assert_illegal_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !fire) |=> !illegal_o);

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !restore_valid) |=> ($stable(mode_o) && !illegal_o));

    assert_branch_unc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && branch_taken && !restore_valid && legal) |=> (mode_o == 2'b00));

    assert_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_valid && restore_mode != 2'b11) |=> (mode_o == $past(restore_mode) && !illegal_o));
endmodule

// File: tb/cmode_seq_bench.sv
module cmode_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_valid = 1'b0, ins_ready = 1'b0;
    logic [1:0] ins_class = 2'b00, ins_switch = 2'b00;
    logic       branch_taken = 1'b0, restore_valid = 1'b0;
    logic [1:0] restore_mode = 2'b00;
    logic [1:0] mode_o;
    logic       illegal_o;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    cmode_seq u_cmode_seq (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_class(ins_class), .ins_switch(ins_switch), .branch_taken(branch_taken),
        .restore_valid(restore_valid), .restore_mode(restore_mode),
        .mode_o(mode_o), .illegal_o(illegal_o)
    );

    task automatic check(input string req, input logic [1:0] exp_mode, input logic exp_ill);
        checks++;
        if (mode_o !== exp_mode || illegal_o !== exp_ill) begin
            fails++;
            $display("FAIL %s: mode=%b illegal=%b expected mode=%b illegal=%b",
                     req, mode_o, illegal_o, exp_mode, exp_ill);
        end
    endtask

    // one cycle of stimulus applied at negedge, sampled at the following negedge
    task automatic step(input logic v, input logic r, input logic [1:0] c,
                        input logic [1:0] s, input logic b,
                        input logic rv, input logic [1:0] rm);
        @(negedge clk);
        ins_valid = v; ins_ready = r; ins_class = c; ins_switch = s;
        branch_taken = b; restore_valid = rv; restore_mode = rm;
        @(negedge clk);
        ins_valid = 0; ins_ready = 0; branch_taken = 0; restore_valid = 0;
    endtask

    task automatic ins(input logic [1:0] c, input logic [1:0] s, input logic b);
        step(1, 1, c, s, b, 0, 2'b00);
    endtask

    task automatic do_reset;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset;
        do_reset();
        check("R1 reset", 2'b00, 1'b0);
    endtask

    task automatic t_uncompressed;
        do_reset();
        ins(2'b11, 2'b01, 0); check("R2 32-bit in unc", 2'b00, 0);
        ins(2'b00, 2'b00, 0); check("R3 10-bit stay", 2'b00, 0);
        ins(2'b00, 2'b01, 0); check("R3 10-bit enter cmp", 2'b01, 0);
    endtask

    task automatic t_compressed;
        do_reset();
        ins(2'b00, 2'b01, 0);
        ins(2'b01, 2'b00, 0); check("R4 16 stay", 2'b01, 0);
        ins(2'b10, 2'b10, 0); check("R5 16+16 holds", 2'b01, 0);
        ins(2'b10, 2'b01, 0); check("R5 16+16 holds sw01", 2'b01, 0);
        ins(2'b01, 2'b01, 0); check("R4 16 slot", 2'b10, 0);
        ins(2'b11, 2'b00, 0); check("R6 slot done", 2'b01, 0);
        ins(2'b01, 2'b10, 0); check("R4 16 leave", 2'b00, 0);
    endtask

    task automatic t_illegal;
        do_reset();
        ins(2'b01, 2'b00, 0); check("R7 16 in unc", 2'b00, 1);
        step(0, 0, 2'b00, 2'b00, 0, 0, 2'b00); check("R8 pulse one cycle", 2'b00, 0);
        ins(2'b10, 2'b00, 1); check("R8 16+16 in unc with branch", 2'b00, 1);
        ins(2'b00, 2'b01, 0);
        ins(2'b11, 2'b00, 0); check("R7 32 in cmp", 2'b01, 1);
        ins(2'b00, 2'b00, 0); check("R7 10 in cmp", 2'b01, 1);
        ins(2'b01, 2'b11, 0); check("R7 16 sw11", 2'b01, 1);
        ins(2'b01, 2'b01, 0);
        ins(2'b01, 2'b00, 0); check("R7 16 in slot", 2'b10, 1);
        ins(2'b11, 2'b00, 0); check("R6 slot still usable", 2'b01, 0);
    endtask

    task automatic t_handshake;
        do_reset();
        step(1, 0, 2'b00, 2'b01, 0, 0, 2'b00); check("R9 valid no ready", 2'b00, 0);
        step(0, 1, 2'b00, 2'b01, 0, 0, 2'b00); check("R9 ready no valid", 2'b00, 0);
        step(0, 1, 2'b01, 2'b00, 0, 0, 2'b00); check("R9 idle illegal class", 2'b00, 0);
    endtask

    task automatic t_branch;
        do_reset();
        ins(2'b00, 2'b01, 1); check("R10 10-bit branch", 2'b00, 0);
        ins(2'b00, 2'b01, 0);
        ins(2'b01, 2'b00, 1); check("R10 16 branch", 2'b00, 0);
        ins(2'b00, 2'b01, 0);
        ins(2'b01, 2'b01, 0);
        ins(2'b11, 2'b00, 1); check("R10 branch beats slot return", 2'b00, 0);
    endtask

    task automatic t_restore;
        do_reset();
        step(0, 0, 2'b00, 2'b00, 0, 1, 2'b10); check("R11 restore slot", 2'b10, 0);
        ins(2'b11, 2'b00, 0); check("R11 restored slot returns", 2'b01, 0);
        step(1, 1, 2'b01, 2'b10, 0, 1, 2'b01); check("R11 restore beats handshake", 2'b01, 0);
        step(1, 1, 2'b11, 2'b00, 0, 1, 2'b11); check("R11 restore code 11", 2'b00, 0);
    endtask

    initial begin
        fork
            begin
                t_reset(); t_uncompressed(); t_compressed(); t_illegal();
                t_handshake(); t_branch(); t_restore();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule